// File: doc/BRIEF.md
# Fused Multiply-Add Special-Operand Resolver

This block sits in front of the arithmetic datapath of a double-precision fused multiply-add unit, which computes z + x*y, or z - x*y when the negate-product control is set. Every operand is sorted into one of six classes: signaling NaN, quiet NaN, zero, denormal, normal or infinity. A fixed priority then decides whether the special operands alone settle the result. When they do, the block gives that result word together with an invalid-operation flag. When they do not, it raises a compute indication so the mantissa datapath does the work, and it gives the product sign that the datapath needs.

The resolver is a single register stage. An operation presented with `in_valid` high appears on the outputs one clock later, with `out_valid` high for that one cycle. All flags and the result are zero in any cycle that carries no result. The parameter `LEGACY_NAN` picks which default NaN pattern an invalid operation produces.

Inside, three identical classifiers feed an arbiter. The arbiter picks one action: quiet z, quiet x, quiet y, pass x, pass y, pass z, default NaN, signed infinity or compute. A result former turns that action into the output word and flags, and the output register captures it.

Top module: `fma_special_resolver`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `out_valid`, `special_valid`, `compute` and `invalid` are low and `special_result` is zero.
- R2: An operation accepted with `in_valid` high appears one clock later with `out_valid` high for exactly one cycle. In every cycle with `out_valid` low, `special_valid`, `compute`, `invalid` and `special_result` are zero.
- R3: Words are sign in bit 63, an 11-bit exponent in bits 62:52 and a 52-bit fraction in bits 51:0. A NaN has the exponent all ones and a nonzero fraction, and is signaling when bit 51 is 0. When z is a signaling NaN, the result is z with bit 51 set and invalid is high, whatever x and y hold.
- R4: When z is not signaling, a signaling x returns x with bit 51 set. Failing that, a signaling y returns y with bit 51 set. Both cases raise invalid.
- R5: With no signaling NaN among the operands, a quiet NaN in x is returned unchanged. Failing that, a quiet NaN in y is returned unchanged. Invalid stays low, and this holds even when z is a quiet NaN.
- R6: An infinite operand multiplied by a zero operand, in either order, gives invalid high and the default NaN. That NaN is 0x7FF8000000000000, or 0x7FF7FFFFFFFFFFFF when `LEGACY_NAN`=1. The exception is a quiet-NaN z, which is returned with invalid low.
- R7: An infinity multiplied by a nonzero finite value or by an infinity gives an infinity whose sign is sign(x) XOR sign(y), regardless of `negate_product`. A quiet-NaN z is returned in its place.
- R8: A zero multiplied by a finite value returns z unchanged, including when z is an infinity, a zero or a quiet NaN.
- R9: With a product of normal or denormal factors, a quiet-NaN or infinite z is returned unchanged. Otherwise `compute` is high, `special_valid` is low and `special_result` is zero. With `out_valid` high, exactly one of `compute` and `special_valid` is high.
- R10: With `out_valid` high, `prod_sign` equals sign(x) XOR sign(y) XOR `negate_product` of that operation.
- R11: A denormal (exponent zero, fraction nonzero) counts as nonzero finite. Denormal times infinity gives an infinity, not invalid, and denormal times denormal gives compute.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operands present this cycle |
| negate_product | input | 1 | High selects z - x*y |
| op_z | input | 64 | Addend |
| op_x | input | 64 | First factor |
| op_y | input | 64 | Second factor |
| out_valid | output | 1 | Result of the previous cycle's operation |
| special_valid | output | 1 | Result settled by special operands |
| special_result | output | 64 | Settled result word |
| invalid | output | 1 | Invalid-operation flag |
| compute | output | 1 | Arithmetic datapath must produce the result |
| prod_sign | output | 1 | Effective product sign for the datapath |

## Verification
The properties assume that the operand words and `negate_product` are only meaningful in a cycle where `in_valid` is high. They also assume the inputs stay steady across the rising edge that samples them. The stimulus changes inputs only on the falling edge and lowers `in_valid` in idle cycles. It runs operations back to back and with gaps, so both the latency rule and the idle-zero rule are exercised. Operand values are drawn from the six classes with both signs, so that each priority step is reached with the competing lower-priority conditions also present.

// File: rtl/fma_sr_pkg.sv
package fma_sr_pkg;

    typedef enum logic [2:0] {
        CLS_ZERO,
        CLS_DENORM,
        CLS_NORMAL,
        CLS_INF,
        CLS_QNAN,
        CLS_SNAN
    } opclass_t;

    typedef enum logic [3:0] {
        ACT_QUIET_Z,
        ACT_QUIET_X,
        ACT_QUIET_Y,
        ACT_PASS_X,
        ACT_PASS_Y,
        ACT_PASS_Z,
        ACT_DEFAULT_NAN,
        ACT_INF_PROD,
        ACT_COMPUTE
    } action_t;

    typedef enum logic [1:0] {
        PK_INF_ZERO,
        PK_INF,
        PK_ZERO,
        PK_FINITE
    } prodkind_t;

endpackage

// File: rtl/fma_sr_classify.sv
module fma_sr_classify
    import fma_sr_pkg::*;
#(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic [WORD_W-1:0] word,
    output opclass_t          cls
);

    logic [EXP_W-1:0]  expo;
    logic [FRAC_W-1:0] frac;
    logic              exp_ones;
    logic              exp_zero;
    logic              frac_zero;

    assign expo      = word[WORD_W-2 -: EXP_W];
    assign frac      = word[FRAC_W-1:0];
    assign exp_ones  = &expo;
    assign exp_zero  = ~|expo;
    assign frac_zero = ~|frac;

    always_comb begin
        if (exp_ones && frac_zero)
            cls = CLS_INF;
        else if (exp_ones && frac[FRAC_W-1])
            cls = CLS_QNAN;
        else if (exp_ones)
            cls = CLS_SNAN;
        else if (exp_zero && frac_zero)
            cls = CLS_ZERO;
        else if (exp_zero)
            cls = CLS_DENORM;
        else
            cls = CLS_NORMAL;
    end

endmodule

// File: rtl/fma_sr_arbiter.sv
module fma_sr_arbiter
    import fma_sr_pkg::*;
(
    input  opclass_t cls_z,
    input  opclass_t cls_x,
    input  opclass_t cls_y,
    output action_t  action
);

    prodkind_t kind;
    logic      any_inf;
    logic      any_zero;
    logic      z_qnan;
    logic      z_inf;

    assign any_inf  = (cls_x == CLS_INF)  || (cls_y == CLS_INF);
    assign any_zero = (cls_x == CLS_ZERO) || (cls_y == CLS_ZERO);
    assign z_qnan   = (cls_z == CLS_QNAN);
    assign z_inf    = (cls_z == CLS_INF);

    always_comb begin
        if (any_inf && any_zero)
            kind = PK_INF_ZERO;
        else if (any_inf)
            kind = PK_INF;
        else if (any_zero)
            kind = PK_ZERO;
        else
            kind = PK_FINITE;
    end

    always_comb begin
        if (cls_z == CLS_SNAN)
            action = ACT_QUIET_Z;
        else if (cls_x == CLS_SNAN)
            action = ACT_QUIET_X;
        else if (cls_y == CLS_SNAN)
            action = ACT_QUIET_Y;
        else if (cls_x == CLS_QNAN)
            action = ACT_PASS_X;
        else if (cls_y == CLS_QNAN)
            action = ACT_PASS_Y;
        else begin
            unique case (kind)
                PK_INF_ZERO: action = z_qnan ? ACT_PASS_Z : ACT_DEFAULT_NAN;
                PK_INF:      action = z_qnan ? ACT_PASS_Z : ACT_INF_PROD;
                PK_ZERO:     action = ACT_PASS_Z;
                PK_FINITE:   action = (z_qnan || z_inf) ? ACT_PASS_Z : ACT_COMPUTE;
                default:     action = ACT_COMPUTE;
            endcase
        end
    end

endmodule

// File: rtl/fma_sr_result.sv
module fma_sr_result
    import fma_sr_pkg::*;
#(
    parameter int EXP_W      = 11,
    parameter int FRAC_W     = 52,
    parameter bit LEGACY_NAN = 1'b0,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  action_t           action,
    input  logic [WORD_W-1:0] op_z,
    input  logic [WORD_W-1:0] op_x,
    input  logic [WORD_W-1:0] op_y,
    output logic [WORD_W-1:0] result,
    output logic              special,
    output logic              invalid,
    output logic              compute
);

    localparam logic [WORD_W-1:0] QUIET_BIT = WORD_W'(1) << (FRAC_W - 1);
    localparam logic [EXP_W-1:0]  EXP_ONES  = {EXP_W{1'b1}};
    localparam logic [FRAC_W-1:0] DFLT_FRAC = LEGACY_NAN ? ({FRAC_W{1'b1}} >> 1)
                                                         : (FRAC_W'(1) << (FRAC_W - 1));
    localparam logic [WORD_W-1:0] DFLT_NAN  = {1'b0, EXP_ONES, DFLT_FRAC};

    logic inf_sign;

    assign inf_sign = op_x[WORD_W-1] ^ op_y[WORD_W-1];

    always_comb begin
        result  = '0;
        special = 1'b1;
        invalid = 1'b0;
        compute = 1'b0;
        unique case (action)
            ACT_QUIET_Z: begin
                result  = op_z | QUIET_BIT;
                invalid = 1'b1;
            end
            ACT_QUIET_X: begin
                result  = op_x | QUIET_BIT;
                invalid = 1'b1;
            end
            ACT_QUIET_Y: begin
                result  = op_y | QUIET_BIT;
                invalid = 1'b1;
            end
            ACT_PASS_X:      result = op_x;
            ACT_PASS_Y:      result = op_y;
            ACT_PASS_Z:      result = op_z;
            ACT_DEFAULT_NAN: begin
                result  = DFLT_NAN;
                invalid = 1'b1;
            end
            ACT_INF_PROD:    result = {inf_sign, EXP_ONES, {FRAC_W{1'b0}}};
            ACT_COMPUTE: begin
                special = 1'b0;
                compute = 1'b1;
            end
            default: begin
                special = 1'b0;
                compute = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/fma_special_resolver.sv
module fma_special_resolver
    import fma_sr_pkg::*;
#(
    parameter int EXP_W      = 11,
    parameter int FRAC_W     = 52,
    parameter bit LEGACY_NAN = 1'b0,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              negate_product,
    input  logic [WORD_W-1:0] op_z,
    input  logic [WORD_W-1:0] op_x,
    input  logic [WORD_W-1:0] op_y,
    output logic              out_valid,
    output logic              special_valid,
    output logic [WORD_W-1:0] special_result,
    output logic              invalid,
    output logic              compute,
    output logic              prod_sign
);

    localparam int N_OPS = 3;

    logic [WORD_W-1:0] ops [N_OPS];
    opclass_t          cls [N_OPS];
    action_t           action;
    logic [WORD_W-1:0] nxt_result;
    logic              nxt_special;
    logic              nxt_invalid;
    logic              nxt_compute;
    logic              nxt_psign;

    assign ops[0] = op_z;
    assign ops[1] = op_x;
    assign ops[2] = op_y;

    for (genvar g = 0; g < N_OPS; g++) begin : g_cls
        fma_sr_classify #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_cls (
            .word (ops[g]),
            .cls  (cls[g])
        );
    end

    fma_sr_arbiter u_arb (
        .cls_z  (cls[0]),
        .cls_x  (cls[1]),
        .cls_y  (cls[2]),
        .action (action)
    );

    fma_sr_result #(.EXP_W(EXP_W), .FRAC_W(FRAC_W), .LEGACY_NAN(LEGACY_NAN)) u_res (
        .action  (action),
        .op_z    (op_z),
        .op_x    (op_x),
        .op_y    (op_y),
        .result  (nxt_result),
        .special (nxt_special),
        .invalid (nxt_invalid),
        .compute (nxt_compute)
    );

    assign nxt_psign = op_x[WORD_W-1] ^ op_y[WORD_W-1] ^ negate_product;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid      <= 1'b0;
            special_valid  <= 1'b0;
            special_result <= '0;
            invalid        <= 1'b0;
            compute        <= 1'b0;
            prod_sign      <= 1'b0;
        end else begin
            out_valid      <= in_valid;
            special_valid  <= in_valid & nxt_special;
            special_result <= in_valid ? nxt_result : '0;
            invalid        <= in_valid & nxt_invalid;
            compute        <= in_valid & nxt_compute;
            prod_sign      <= in_valid & nxt_psign;
        end
    end

endmodule

// File: rtl/fma_sr_checker.sv
module fma_sr_checker #(
    parameter int EXP_W  = 11,
    parameter int FRAC_W = 52,
    localparam int WORD_W = 1 + EXP_W + FRAC_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_valid,
    input logic              negate_product,
    input logic [WORD_W-1:0] op_z,
    input logic [WORD_W-1:0] op_x,
    input logic [WORD_W-1:0] op_y,
    input logic              out_valid,
    input logic              special_valid,
    input logic [WORD_W-1:0] special_result,
    input logic              invalid,
    input logic              compute,
    input logic              prod_sign
);

    logic z_snan_in;
    logic res_is_nan;

    assign z_snan_in  = (&op_z[WORD_W-2 -: EXP_W]) && !op_z[FRAC_W-1] && (|op_z[FRAC_W-1:0]);
    assign res_is_nan = (&special_result[WORD_W-2 -: EXP_W]) && (|special_result[FRAC_W-1:0]);

    assert_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    assert_no_stray_valid_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);

    assert_idle_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> !(special_valid || compute || invalid || (|special_result)));

    assert_one_outcome_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (special_valid ^ compute));

    assert_invalid_special_R4: assert property (@(posedge clk) disable iff (!rst_n)
        invalid |-> (special_valid && res_is_nan));

    assert_zsnan_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && z_snan_in) |=>
            (invalid && special_result == ($past(op_z) | (WORD_W'(1) << (FRAC_W - 1)))));

    assert_psign_R10: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> (prod_sign == ($past(op_x[WORD_W-1]) ^ $past(op_y[WORD_W-1]) ^ $past(negate_product))));

endmodule

bind fma_special_resolver fma_sr_checker #(.EXP_W(EXP_W), .FRAC_W(FRAC_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .in_valid       (in_valid),
    .negate_product (negate_product),
    .op_z           (op_z),
    .op_x           (op_x),
    .op_y           (op_y),
    .out_valid      (out_valid),
    .special_valid  (special_valid),
    .special_result (special_result),
    .invalid        (invalid),
    .compute        (compute),
    .prod_sign      (prod_sign)
);

// File: tb/fma_special_resolver_test.sv
module fma_special_resolver_test;

    localparam int CLK_PERIOD = 10;

    localparam logic [63:0] P_ONE  = 64'h3FF0_0000_0000_0000;
    localparam logic [63:0] N_ONE  = 64'hBFF0_0000_0000_0000;
    localparam logic [63:0] P_TWO  = 64'h4000_0000_0000_0000;
    localparam logic [63:0] P_ZERO = 64'h0000_0000_0000_0000;
    localparam logic [63:0] N_ZERO = 64'h8000_0000_0000_0000;
    localparam logic [63:0] P_DEN  = 64'h0000_0000_0000_0001;
    localparam logic [63:0] N_DEN  = 64'h8000_0000_0000_0F00;
    localparam logic [63:0] P_INF  = 64'h7FF0_0000_0000_0000;
    localparam logic [63:0] N_INF  = 64'hFFF0_0000_0000_0000;
    localparam logic [63:0] QN_A   = 64'h7FF8_0000_0000_00A5;
    localparam logic [63:0] QN_B   = 64'hFFF8_0000_0000_0B00;
    localparam logic [63:0] SN_A   = 64'h7FF0_0000_0000_0123;
    localparam logic [63:0] SN_B   = 64'hFFF4_0000_0000_0001;
    localparam logic [63:0] SN_C   = 64'h7FF0_0000_0004_0000;
    localparam logic [63:0] QBIT   = 64'h0008_0000_0000_0000;
    localparam logic [63:0] DNAN   = 64'h7FF8_0000_0000_0000;

    typedef struct {
        logic        sv;
        logic [63:0] res;
        logic        inv;
        logic        comp;
        logic        psign;
        string       tag;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic        negate_product = 1'b0;
    logic [63:0] op_z = '0;
    logic [63:0] op_x = '0;
    logic [63:0] op_y = '0;
    logic        out_valid;
    logic        special_valid;
    logic [63:0] special_result;
    logic        invalid;
    logic        compute;
    logic        prod_sign;

    int   n_checks = 0;
    int   n_fails  = 0;
    logic run_on   = 1'b0;
    exp_t sb[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    fma_special_resolver uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .in_valid       (in_valid),
        .negate_product (negate_product),
        .op_z           (op_z),
        .op_x           (op_x),
        .op_y           (op_y),
        .out_valid      (out_valid),
        .special_valid  (special_valid),
        .special_result (special_result),
        .invalid        (invalid),
        .compute        (compute),
        .prod_sign      (prod_sign)
    );

    function automatic bit f_nan(logic [63:0] w);
        return (w[62:52] == 11'h7FF) && (w[51:0] != 0);
    endfunction
    function automatic bit f_snan(logic [63:0] w);
        return f_nan(w) && !w[51];
    endfunction
    function automatic bit f_qnan(logic [63:0] w);
        return f_nan(w) && w[51];
    endfunction
    function automatic bit f_inf(logic [63:0] w);
        return (w[62:52] == 11'h7FF) && (w[51:0] == 0);
    endfunction
    function automatic bit f_zero(logic [63:0] w);
        return w[62:0] == 0;
    endfunction

    function automatic exp_t model(logic [63:0] z, logic [63:0] x, logic [63:0] y,
                                   logic neg, string tag);
        exp_t e;
        bit   has_inf;
        bit   has_zero;
        e.sv = 1'b1; e.res = '0; e.inv = 1'b0; e.comp = 1'b0; e.tag = tag;
        e.psign = x[63] ^ y[63] ^ neg;
        has_inf  = f_inf(x) || f_inf(y);
        has_zero = f_zero(x) || f_zero(y);
        if (f_snan(z)) begin e.res = z | QBIT; e.inv = 1'b1; end
        else if (f_snan(x)) begin e.res = x | QBIT; e.inv = 1'b1; end
        else if (f_snan(y)) begin e.res = y | QBIT; e.inv = 1'b1; end
        else if (f_qnan(x)) e.res = x;
        else if (f_qnan(y)) e.res = y;
        else if (has_inf && has_zero) begin
            if (f_qnan(z)) e.res = z;
            else begin e.res = DNAN; e.inv = 1'b1; end
        end
        else if (has_inf) e.res = f_qnan(z) ? z : {x[63] ^ y[63], 11'h7FF, 52'h0};
        else if (has_zero) e.res = z;
        else if (f_qnan(z) || f_inf(z)) e.res = z;
        else begin e.sv = 1'b0; e.comp = 1'b1; end
        return e;
    endfunction

    task automatic check1(string tag, string what, logic [63:0] act, logic [63:0] expv);
        n_checks++;
        if (act !== expv) begin
            n_fails++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, expv);
        end
    endtask

    task automatic drive(logic [63:0] z, logic [63:0] x, logic [63:0] y, logic neg, string tag);
        sb.push_back(model(z, x, y, neg, tag));
        op_z = z; op_x = x; op_y = y; negate_product = neg; in_valid = 1'b1;
        @(negedge clk);
        in_valid = 1'b0; op_z = '0; op_x = '0; op_y = '0; negate_product = 1'b0;
    endtask

    task automatic gap(int n);
        repeat (n) @(negedge clk);
    endtask

    always @(negedge clk) begin
        if (run_on) begin
            if (out_valid === 1'b1) begin
                exp_t e;
                if (sb.size() == 0) begin
                    n_checks++; n_fails++;
                    $display("FAIL R2 unexpected result: actual out_valid 1 expected 0");
                end else begin
                    e = sb.pop_front();
                    check1(e.tag, "special_valid", 64'(special_valid), 64'(e.sv));
                    check1(e.tag, "special_result", special_result, e.res);
                    check1(e.tag, "invalid", 64'(invalid), 64'(e.inv));
                    check1(e.tag, "compute", 64'(compute), 64'(e.comp));
                    check1("R10", "prod_sign", 64'(prod_sign), 64'(e.psign));
                end
            end else begin
                check1("R2", "idle outputs",
                       {58'h0, out_valid, special_valid, invalid, compute, prod_sign, |special_result},
                       64'h0);
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_checks++; n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check1("R1", "outputs in reset",
               {59'h0, out_valid, special_valid, invalid, compute, |special_result}, 64'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check1("R1", "outputs after reset",
               {59'h0, out_valid, special_valid, invalid, compute, |special_result}, 64'h0);
        run_on = 1'b1;

        drive(SN_A, QN_A, SN_B, 1'b0, "R3");
        drive(SN_B, P_INF, P_ZERO, 1'b1, "R3");
        drive(P_ONE, SN_C, SN_B, 1'b0, "R4");
        drive(P_ONE, QN_A, SN_B, 1'b0, "R4");
        drive(QN_B, P_ONE, SN_A, 1'b1, "R4");
        gap(2);
        drive(P_ONE, QN_A, QN_B, 1'b0, "R5");
        drive(QN_A, P_ONE, QN_B, 1'b0, "R5");
        drive(P_ONE, P_INF, QN_A, 1'b0, "R5");
        drive(P_ONE, P_INF, P_ZERO, 1'b0, "R6");
        drive(N_INF, N_ZERO, N_INF, 1'b1, "R6");
        drive(QN_A, P_ZERO, N_INF, 1'b0, "R6");
        gap(1);
        drive(P_ONE, P_INF, N_ONE, 1'b0, "R7");
        drive(P_ONE, P_INF, N_ONE, 1'b1, "R7");
        drive(P_INF, N_INF, N_INF, 1'b0, "R7");
        drive(QN_B, N_INF, N_INF, 1'b0, "R7");
        drive(N_INF, P_ZERO, P_TWO, 1'b0, "R8");
        drive(P_TWO, N_ZERO, N_DEN, 1'b0, "R8");
        drive(QN_A, P_ZERO, P_ZERO, 1'b1, "R8");
        drive(N_ZERO, P_ZERO, P_ONE, 1'b0, "R8");
        gap(3);
        drive(P_ONE, P_ONE, P_TWO, 1'b0, "R9");
        drive(N_ONE, N_ONE, P_TWO, 1'b1, "R9");
        drive(P_INF, P_ONE, P_TWO, 1'b0, "R9");
        drive(QN_B, N_ONE, P_TWO, 1'b0, "R9");
        drive(P_ONE, P_DEN, P_INF, 1'b0, "R11");
        drive(P_ZERO, P_DEN, N_DEN, 1'b0, "R11");
        drive(N_INF, N_DEN, P_ONE, 1'b1, "R11");
        gap(3);

        check1("R2", "pending results", 64'(sb.size()), 64'h0);
        run_on = 1'b0;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule